// File: doc/BRIEF.md
# Radix-4 Booth Multiplier, 8 by 8, Dual Mode

This block multiplies two 8-bit operands and returns a 16-bit product one clock after the operands are offered. The multiplier operand is recoded into radix-4 digits from the set {-2, -1, 0, +1, +2}. Each digit selects a multiple of the multiplicand, weighted by a power of four. A balanced tree of plain adders sums these multiples.

A mode input chooses how both operands are read. In signed mode they are two's complement values. In unsigned mode they are plain binary values. Both modes use the same recoder. The multiplier is widened to ten bits by sign extension in signed mode and by zero extension in unsigned mode, so there are always five recoding windows. In unsigned mode the fifth window carries the weight that an unsigned top bit needs, which keeps the product exact.

The output is a register stage with a strobe. When `in_valid` is high at a clock edge, the product of the operands present at that edge is captured, and `out_valid` is high for the following cycle. Without a new strobe the product register holds its value.

Top module: `r4b_mult_top`

## Requirements
- R1: The multiplier, widened to ten bits, is scanned in overlapping three-bit windows. Window i covers widened bits 2i+1, 2i and 2i-1, and a constant 0 stands below bit 0 for window 0.
- R2: Each window (high, mid, low) maps to a digit as follows. 000 and 111 give 0. 001 and 010 give +1. 011 gives +2. 100 gives -2. 101 and 110 give -1.
- R3: Window i contributes its digit times the multiplicand times 4^i to the sum. Negative multiples are formed as two's complements.
- R4: With `signed_mode`=1, a captured product equals the exact two's complement product of `mcand` and `mplier` as a 16-bit value, including -128 x -128 = 16384.
- R5: With `signed_mode`=0, a captured product equals the exact unsigned product of `mcand` and `mplier`, including 255 x 255 = 65025.
- R6: With `signed_mode`=1, the fifth window always yields digit 0, so it adds nothing.
- R7: When `in_valid` is 1 at a rising edge, `product` shows that pair's result and `out_valid` is 1 after that edge. `out_valid` is 0 after any edge where `in_valid` was 0.
- R8: After an edge with `in_valid`=0, `product` keeps its previous value whatever the operands and the mode do.
- R9: A synchronous active-high `rst` clears `product` to 0 and `out_valid` to 0, and it takes priority over a simultaneous `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are to be captured at this edge |
| signed_mode | input | 1 | 1: two's complement operands, 0: unsigned operands |
| mcand | input | 8 | Multiplicand |
| mplier | input | 8 | Multiplier (the recoded operand) |
| product | output | 16 | Registered product |
| out_valid | output | 1 | High for one cycle after each captured pair |

## Verification
Two events can land on the same edge: a reset and a fresh operand pair with `in_valid` high. The bench raises both together after a non-zero product has been captured. It then expects a zero product and a low strobe, and it expects the next ordinary capture to work normally.

The bench also streams a new pair on every cycle while the previous result is being read. It covers every operand pair in both modes, so capture and presentation overlap on every edge, and each cycle is checked against a behavioural multiply.

// File: rtl/r4b_pkg.sv
package r4b_pkg;

    localparam int OP_W    = 8;
    localparam int PROD_W  = 2 * OP_W;
    localparam int EXT_W   = OP_W + 2;           // widened multiplier
    localparam int NGRP    = EXT_W / 2;          // recoding windows
    localparam int MC_W    = OP_W + 1;           // widened multiplicand
    localparam int LEAVES  = 2 ** $clog2(NGRP);  // adder tree leaves

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } op_mode_e;

    // one recoded digit: sign plus one-hot magnitude
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

    function automatic booth_dig_t recode_window(input logic [2:0] w);
        booth_dig_t d;
        d = '0;
        unique case (w)
            3'b001, 3'b010: d.one = 1'b1;
            3'b011:         d.two = 1'b1;
            3'b100: begin d.neg = 1'b1; d.two = 1'b1; end
            3'b101, 3'b110: begin d.neg = 1'b1; d.one = 1'b1; end
            default:        d = '0;
        endcase
        return d;
    endfunction

    function automatic logic [MC_W-1:0] widen_mcand(input logic [OP_W-1:0] v,
                                                     input op_mode_e m);
        return (m == MODE_SIGNED) ? {v[OP_W-1], v} : {1'b0, v};
    endfunction

    function automatic logic [EXT_W-1:0] widen_mplier(input logic [OP_W-1:0] v,
                                                       input op_mode_e m);
        return (m == MODE_SIGNED) ? {{(EXT_W-OP_W){v[OP_W-1]}}, v}
                                  : {{(EXT_W-OP_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/r4b_recoder.sv
module r4b_recoder
    import r4b_pkg::*;
(
    input  logic [EXT_W-1:0] mext,
    output booth_dig_t       digs [NGRP]
);
    localparam int PAD_W = EXT_W + 1;

    // constant zero placed below bit 0 for the first window
    logic [PAD_W-1:0] padded;
    assign padded = {mext, 1'b0};

    for (genvar g = 0; g < NGRP; g++) begin : g_win
        assign digs[g] = recode_window(padded[2*g+2 : 2*g]);
    end
endmodule

// File: rtl/r4b_ppgen.sv
module r4b_ppgen
    import r4b_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [MC_W-1:0]   mc_ext,
    input  booth_dig_t        dig,
    output logic [PROD_W-1:0] pp
);
    localparam int SHIFT = 2 * IDX;

    logic [PROD_W-1:0] m_full;
    logic [PROD_W-1:0] mag;
    logic [PROD_W-1:0] signed_mag;

    assign m_full = {{(PROD_W-MC_W){mc_ext[MC_W-1]}}, mc_ext};

    always_comb begin
        mag = '0;
        if (dig.one)      mag = m_full;
        else if (dig.two) mag = m_full << 1;
        signed_mag = dig.neg ? (~mag + 1'b1) : mag;
    end

    assign pp = signed_mag << SHIFT;
endmodule

// File: rtl/r4b_sum.sv
module r4b_sum
    import r4b_pkg::*;
(
    input  logic [PROD_W-1:0] pps [NGRP],
    output logic [PROD_W-1:0] total
);
    // heap-indexed tree: node 1 is the root, leaves sit at LEAVES..2*LEAVES-1
    logic [PROD_W-1:0] node [1:2*LEAVES-1];

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < NGRP) begin : g_used
            assign node[LEAVES+l] = pps[l];
        end else begin : g_pad
            assign node[LEAVES+l] = '0;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_add
        assign node[k] = node[2*k] + node[2*k+1];
    end

    assign total = node[1];
endmodule

// File: rtl/r4b_mult_top.sv
module r4b_mult_top
    import r4b_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                signed_mode,
    input  logic [OP_W-1:0]     mcand,
    input  logic [OP_W-1:0]     mplier,
    output logic [PROD_W-1:0]   product,
    output logic                out_valid
);
    op_mode_e          mode;
    logic [EXT_W-1:0]  mext;
    logic [MC_W-1:0]   mcext;
    booth_dig_t        digs [NGRP];
    logic [PROD_W-1:0] pps  [NGRP];
    logic [PROD_W-1:0] sum_w;

    assign mode  = op_mode_e'(signed_mode);
    assign mext  = widen_mplier(mplier, mode);
    assign mcext = widen_mcand(mcand, mode);

    r4b_recoder u_rec (
        .mext (mext),
        .digs (digs)
    );

    for (genvar i = 0; i < NGRP; i++) begin : g_pp
        r4b_ppgen #(.IDX(i)) u_pp (
            .mc_ext (mcext),
            .dig    (digs[i]),
            .pp     (pps[i])
        );
    end

    r4b_sum u_sum (
        .pps   (pps),
        .total (sum_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            product   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product <= sum_w;
        end
    end

    // R6
    top_window_idle_chk: assert property (@(posedge clk) disable iff (rst)
        signed_mode |-> (digs[NGRP-1] == '0));

    // R4
    signed_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && signed_mode) |=>
        product == $past(PROD_W'({{OP_W{mcand[OP_W-1]}}, mcand} *
                                 {{OP_W{mplier[OP_W-1]}}, mplier})));

    // R5
    unsigned_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !signed_mode) |=>
        product == $past(PROD_W'({{OP_W{1'b0}}, mcand} * {{OP_W{1'b0}}, mplier})));

    // R7
    strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (product == '0 && !out_valid));
endmodule

// File: tb/r4b_mult_top_bench.sv
module r4b_mult_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        signed_mode = 1'b0;
    logic [7:0]  mcand = '0;
    logic [7:0]  mplier = '0;
    logic [15:0] product;
    logic        out_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    r4b_mult_top u_r4b_mult_top (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .signed_mode (signed_mode),
        .mcand       (mcand),
        .mplier      (mplier),
        .product     (product),
        .out_valid   (out_valid)
    );

    function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                            input logic sm);
        logic [15:0] ea, eb;
        ea = sm ? {{8{a[7]}}, a} : {8'h00, a};
        eb = sm ? {{8{b[7]}}, b} : {8'h00, b};
        return 16'(ea * eb);
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply one pair, read the result one edge later
    task automatic one_pair(input logic [7:0] a, input logic [7:0] b, input logic sm,
                            input string req);
        logic [15:0] e;
        e = ref_mul(a, b, sm);
        @(negedge clk);
        mcand = a; mplier = b; signed_mode = sm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(product == e && out_valid, req, product, e);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(product == 16'h0, "R9 reset product", product, 16'h0);
        check(!out_valid, "R9 reset strobe", {15'b0, out_valid}, 16'h0);
        rst = 1'b0;
    endtask

    task automatic t_recode_rows();
        // multiplier low bits walk every window row of R1/R2 with weights of R3
        for (int v = 0; v < 16; v++) one_pair(8'd37, 8'(v), 1'b0, "R1 R2 R3 low windows");
        one_pair(8'd37, 8'b0110_0110, 1'b1, "R2 R3 mixed digits");
        one_pair(8'd200, 8'b1010_1010, 1'b1, "R2 R3 negative digits");
        one_pair(8'hC4, 8'h3B, 1'b1, "R3 negative multiplicand");
    endtask

    task automatic t_signed_corners();
        one_pair(8'h80, 8'h80, 1'b1, "R4 R6 -128*-128");
        check(product == 16'h4000, "R4 -128*-128 value", product, 16'h4000);
        one_pair(8'h80, 8'h7F, 1'b1, "R4 R6 -128*127");
        one_pair(8'hFF, 8'hFF, 1'b1, "R4 R6 -1*-1");
    endtask

    task automatic t_unsigned_corners();
        one_pair(8'hFF, 8'hFF, 1'b0, "R5 255*255");
        check(product == 16'hFE01, "R5 255*255 value", product, 16'hFE01);
        one_pair(8'h80, 8'hFF, 1'b0, "R5 128*255");
        one_pair(8'hFF, 8'h80, 1'b0, "R5 255*128");
    endtask

    task automatic t_strobe();
        one_pair(8'd3, 8'd5, 1'b0, "R7 capture");
        @(negedge clk);
        check(!out_valid, "R7 strobe one cycle", {15'b0, out_valid}, 16'h0);
    endtask

    task automatic t_hold();
        logic [15:0] kept;
        one_pair(8'd99, 8'd77, 1'b0, "R8 seed");
        kept = product;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            mcand = 8'(k * 41 + 7); mplier = 8'(k * 13 + 200); signed_mode = k[0];
            check(product == kept, "R8 hold", product, kept);
        end
        @(negedge clk);
        check(product == kept, "R8 hold final", product, kept);
    endtask

    task automatic t_reset_collide();
        one_pair(8'd50, 8'd60, 1'b0, "R9 seed");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; mcand = 8'd11; mplier = 8'd12;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check(product == 16'h0, "R9 reset beats capture", product, 16'h0);
        check(!out_valid, "R9 reset beats strobe", {15'b0, out_valid}, 16'h0);
        one_pair(8'd11, 8'd12, 1'b0, "R9 capture after reset");
    endtask

    task automatic t_exhaustive();
        bit pend = 0;
        logic [15:0] e = '0;
        for (int sm = 0; sm < 2; sm++) begin
            for (int p = 0; p < 65536; p++) begin
                @(negedge clk);
                if (pend)
                    check(product == e && out_valid,
                          sm == 0 ? "R5 exhaustive" : "R4 exhaustive", product, e);
                mcand = 8'(p >> 8); mplier = 8'(p); signed_mode = sm[0];
                in_valid = 1'b1;
                e = ref_mul(8'(p >> 8), 8'(p), sm[0]);
                pend = 1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(product == e && out_valid, "R4 exhaustive last", product, e);
    endtask

    initial begin
        t_reset();
        t_recode_rows();
        t_signed_corners();
        t_unsigned_corners();
        t_strobe();
        t_hold();
        t_reset_collide();
        t_exhaustive();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule